// File: doc/BRIEF.md
# Instruction prefetch queue

This block keeps a decoder supplied with instruction words without borrowing the main arithmetic unit. It owns a 16-bit instruction counter that addresses memory for each fetch and steps by one after every word it accepts. Returned words move through two look-ahead stages, a next-word register and a current-instruction register, and an immediate register captures the operand word of two-word instructions. A redirect (reset, jump or branch) loads a new address into the counter, empties the queue, and the queue refills with two back-to-back fetches.

The fetch interface is a request/acknowledge pair. The block holds `fetch_req` high with `fetch_addr` stable until a cycle with `fetch_ack` high, which transfers `fetch_data`. The decoder watches `cur_instr` and reports through `has_imm` whether that instruction carries an immediate word. It reads the instruction once `cur_valid` is high and retires it with a one-cycle `consume` pulse. A 16-bit instruction executes from the current register while the next register holds its successor. For a two-word instruction the two halves sit in the current and immediate registers.

A five-state machine controls the queue:
- EMPTY (first refill fetch)
- SHIFT (refill fetch that advances the queue)
- READY (current instruction present, immediate need being checked)
- EXTRA (one more fetch for a two-word instruction)
- WIDE (two-word instruction complete)

Transitions:
- EMPTY→SHIFT on an accepted word.
- SHIFT→READY on an accepted word.
- READY→EXTRA when `has_imm` is high.
- READY→SHIFT on `consume`.
- EXTRA→WIDE on an accepted word.
- WIDE→SHIFT on `consume`.
- Any state→EMPTY on `redirect`.

Top module: `ifetch_queue`

## Requirements
- R1: After reset the queue is in the EMPTY state: `fetch_req` is 1, `fetch_addr` equals the reset address (0 by default), `cur_valid` is 0 and all three stage registers read 0.
- R2: A word is accepted when `fetch_req`, `fetch_ack` are both high and `redirect` is low. On each accepted word `fetch_addr` rises by one in the following cycle, wrapping from 0xFFFF to 0x0000. Without an accepted word `fetch_addr` holds, and `fetch_ack` while `fetch_req` is low changes nothing.
- R3: `redirect` loads `redirect_addr` into `fetch_addr` for the next cycle, drops `cur_valid` and returns to EMPTY. A word acknowledged in the same cycle as `redirect` is discarded: no stage register changes and the counter does not step.
- R4: The first word accepted in EMPTY is written to `next_instr` only.
- R5: The word accepted in SHIFT is written to both `next_instr` and `imm_data`, and in the same cycle the previous `next_instr` moves to `cur_instr`.
- R6: In READY with `has_imm` low, and in WIDE, `cur_valid` is 1 and `fetch_req` is 0; the state holds until `consume` or `redirect`.
- R7: In READY with `has_imm` high, `cur_valid` is 0 and exactly one EXTRA fetch follows. Its word is written to `next_instr` only while `cur_instr` and `imm_data` keep their values, after which `cur_valid` is 1.
- R8: `consume` while `cur_valid` is 1 drops `cur_valid` in the next cycle and starts a SHIFT fetch; `consume` while `cur_valid` is 0 has no effect.
- R9: The instruction, memory and read indicators are all 1 exactly in the cycles where `fetch_req` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect | input | 1 | Load a new fetch address and flush the queue |
| redirect_addr | input | 16 | Target address for a redirect |
| fetch_req | output | 1 | Fetch request pending |
| fetch_addr | output | 16 | Address of the pending fetch (instruction counter) |
| ind_instr | output | 1 | Bus cycle is an instruction read |
| ind_mem | output | 1 | Bus cycle targets memory |
| ind_read | output | 1 | Bus cycle is a read |
| fetch_ack | input | 1 | Returned word present on `fetch_data` |
| fetch_data | input | 16 | Returned instruction word |
| has_imm | input | 1 | Decoder: current instruction carries an immediate word |
| consume | input | 1 | Decoder: retire the current instruction (one-cycle pulse) |
| cur_instr | output | 16 | Current instruction register |
| next_instr | output | 16 | Next-word register |
| imm_data | output | 16 | Immediate operand register |
| cur_valid | output | 1 | Current instruction complete and ready for decode |

## Verification
A wrong state or a mis-steered load shows up at the decoder boundary at the next `cur_valid`. That decode presents a word from the wrong address, a stale operand in `imm_data`, or a `next_instr` that is one word ahead or behind. A counter that skips or stalls shows directly on `fetch_addr` in the cycle after the accepted word. A missing EXTRA fetch or a flush that fails to discard a word corrupts every instruction that follows. The bench sweeps several start addresses, including the wrap at the top of the address space, across memory latencies and decoder consume delays. It compares every decoded instruction with an address-derived word pattern.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY = 3'd0,
        ST_SHIFT = 3'd1,
        ST_READY = 3'd2,
        ST_EXTRA = 3'd3,
        ST_WIDE  = 3'd4
    } ifq_state_t;

    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_FIRST = 2'd1,
        LD_SHIFT = 2'd2,
        LD_NEXT  = 2'd3
    } ifq_load_t;

endpackage

// File: rtl/ifq_counter.sv
module ifq_counter #(
    parameter int          AW         = 16,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= RESET_ADDR;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (inc) begin
            addr_q <= addr_q + STEP;
        end
    end

    assign addr = addr_q;

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (addr_q == $past(addr_q) + STEP));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(addr_q));

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_q == $past(load_addr)));

endmodule

// File: rtl/ifq_fsm.sv
module ifq_fsm
    import ifq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      redirect,
    input  logic      fetch_ack,
    input  logic      has_imm,
    input  logic      consume,
    output logic      fetch_req,
    output logic      take,
    output ifq_load_t ld,
    output logic      cur_valid
);
    ifq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    assign take = fetch_req && fetch_ack && !redirect;

    always_comb begin
        state_d = state_q;
        if (redirect) begin
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: if (take) state_d = ST_SHIFT;
                ST_SHIFT: if (take) state_d = ST_READY;
                ST_READY: begin
                    if (has_imm)      state_d = ST_EXTRA;
                    else if (consume) state_d = ST_SHIFT;
                end
                ST_EXTRA: if (take) state_d = ST_WIDE;
                ST_WIDE:  if (consume) state_d = ST_SHIFT;
                default:  state_d = ST_EMPTY;
            endcase
        end
    end

    always_comb begin
        fetch_req = 1'b0;
        cur_valid = 1'b0;
        ld        = LD_NONE;
        unique case (state_q)
            ST_EMPTY: begin
                fetch_req = 1'b1;
                if (take) ld = LD_FIRST;
            end
            ST_SHIFT: begin
                fetch_req = 1'b1;
                if (take) ld = LD_SHIFT;
            end
            ST_READY: cur_valid = !has_imm;
            ST_EXTRA: begin
                fetch_req = 1'b1;
                if (take) ld = LD_NEXT;
            end
            ST_WIDE:  cur_valid = 1'b1;
            default:  ;
        endcase
    end

    a_r6_no_fetch_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid |-> !fetch_req);

    a_r3_flush: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (fetch_req && !cur_valid));

    a_r7_extra_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && has_imm && !redirect) |=> (fetch_req && !cur_valid));

    a_r8_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && consume && !redirect) |=> (!cur_valid && fetch_req));

endmodule

// File: rtl/ifq_stages.sv
module ifq_stages
    import ifq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ifq_load_t     ld,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] cur,
    output logic [DW-1:0] nxt,
    output logic [DW-1:0] imm
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
            nxt <= '0;
            imm <= '0;
        end else begin
            unique case (ld)
                LD_FIRST: nxt <= word;
                LD_SHIFT: begin
                    cur <= nxt;
                    nxt <= word;
                    imm <= word;
                end
                LD_NEXT:  nxt <= word;
                default:  ;
            endcase
        end
    end

    a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (ld == LD_SHIFT) |=> (cur == $past(nxt) && imm == nxt));

    a_r7_imm_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ld == LD_NEXT) |=> ($stable(imm) && $stable(cur)));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld == LD_NONE) |=> ($stable(imm) && $stable(cur) && $stable(nxt)));

endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
    import ifq_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            DW         = 16,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect,
    input  logic [AW-1:0] redirect_addr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic          ind_instr,
    output logic          ind_mem,
    output logic          ind_read,
    input  logic          fetch_ack,
    input  logic [DW-1:0] fetch_data,
    input  logic          has_imm,
    input  logic          consume,
    output logic [DW-1:0] cur_instr,
    output logic [DW-1:0] next_instr,
    output logic [DW-1:0] imm_data,
    output logic          cur_valid
);
    logic      take;
    ifq_load_t ld;

    ifq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .redirect  (redirect),
        .fetch_ack (fetch_ack),
        .has_imm   (has_imm),
        .consume   (consume),
        .fetch_req (fetch_req),
        .take      (take),
        .ld        (ld),
        .cur_valid (cur_valid)
    );

    ifq_counter #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (redirect),
        .load_addr (redirect_addr),
        .inc       (take),
        .addr      (fetch_addr)
    );

    ifq_stages #(.DW(DW)) u_stg (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld),
        .word  (fetch_data),
        .cur   (cur_instr),
        .nxt   (next_instr),
        .imm   (imm_data)
    );

    assign ind_instr = fetch_req;
    assign ind_mem   = fetch_req;
    assign ind_read  = fetch_req;

    a_r2_addr_moves_only_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !(fetch_req && fetch_ack)) |=> $stable(fetch_addr));

endmodule

// File: tb/ifetch_queue_test.sv
`timescale 1ns/1ps
module ifetch_queue_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect = 1'b0;
    logic [15:0] redirect_addr = '0;
    logic        fetch_req, ind_instr, ind_mem, ind_read, cur_valid;
    logic [15:0] fetch_addr, cur_instr, next_instr, imm_data;
    logic        fetch_ack;
    logic [15:0] fetch_data;
    logic        has_imm;
    logic        consume = 1'b0;

    logic        resp_en = 1'b0;
    logic        resp_ack = 1'b0;
    logic [15:0] resp_data = '0;
    logic        man_ack = 1'b0;
    logic [15:0] man_data = '0;
    int          lat = 0;
    int          wcnt = 0;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign fetch_ack  = resp_en ? resp_ack  : man_ack;
    assign fetch_data = resp_en ? resp_data : man_data;
    // bench decoder: bit 2 of an instruction word marks a trailing immediate
    assign has_imm = cur_instr[2];

    ifetch_queue uut (
        .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_addr(redirect_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .ind_instr(ind_instr), .ind_mem(ind_mem), .ind_read(ind_read),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .has_imm(has_imm), .consume(consume),
        .cur_instr(cur_instr), .next_instr(next_instr), .imm_data(imm_data),
        .cur_valid(cur_valid)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        logic [31:0] p;
        p = 32'(a) * 32'd40503;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // memory model: acknowledges a pending request after lat idle cycles
    always @(negedge clk) begin
        if (!resp_en || !fetch_req) begin
            resp_ack = 1'b0;
            wcnt = 0;
        end else if (wcnt >= lat) begin
            resp_ack  = 1'b1;
            resp_data = mem_word(fetch_addr);
            wcnt = 0;
        end else begin
            resp_ack = 1'b0;
            wcnt++;
        end
    end

    task automatic man_word(input logic [15:0] d);
        man_ack = 1'b1;
        man_data = d;
        @(negedge clk);
        man_ack = 1'b0;
    endtask

    task automatic run_stream(input logic [15:0] start, input int cdel, input int n);
        logic [15:0] e;
        int guard;
        resp_en = 1'b1;
        redirect = 1'b1;
        redirect_addr = start;
        @(negedge clk);
        redirect = 1'b0;
        chk("R3 redirect addr", fetch_addr, start);
        chk("R3 flush valid", cur_valid, 0);
        chk("R9 indicators", {ind_instr, ind_mem, ind_read}, {3{fetch_req}});
        e = start;
        for (int i = 0; i < n; i++) begin
            guard = 0;
            while (!cur_valid && guard < 200) begin
                @(negedge clk);
                guard++;
            end
            chk("R6 decode reached", cur_valid, 1);
            chk("R5 cur word", cur_instr, mem_word(e));
            if (has_imm) begin
                chk("R7 imm word", imm_data, mem_word(e + 16'd1));
                chk("R7 next word", next_instr, mem_word(e + 16'd2));
                e = e + 16'd2;
            end else begin
                chk("R5 next word", next_instr, mem_word(e + 16'd1));
                e = e + 16'd1;
            end
            chk("R6 no fetch", fetch_req, 0);
            chk("R9 indicators", {ind_instr, ind_mem, ind_read}, 3'b000);
            for (int k = 0; k < cdel; k++) begin
                @(negedge clk);
                chk("R6 hold valid", cur_valid, 1);
            end
            consume = 1'b1;
            @(negedge clk);
            consume = 1'b0;
            chk("R8 consume drops valid", cur_valid, 0);
            chk("R8 refill request", fetch_req, 1);
        end
        resp_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 fetch_req", fetch_req, 1);
        chk("R1 fetch_addr", fetch_addr, 16'h0000);
        chk("R1 cur_valid", cur_valid, 0);
        chk("R1 stages", {cur_instr, next_instr}, 32'h0);
        chk("R1 imm", imm_data, 16'h0);
        chk("R9 indicators high", {ind_instr, ind_mem, ind_read}, 3'b111);
        @(negedge clk);

        // R3: word acknowledged together with a redirect is discarded
        man_ack = 1'b1; man_data = 16'hBEEF;
        redirect = 1'b1; redirect_addr = 16'h1234;
        @(negedge clk);
        man_ack = 1'b0; redirect = 1'b0;
        chk("R3 load addr", fetch_addr, 16'h1234);
        chk("R3 discard", next_instr, 16'h0000);
        @(negedge clk);
        chk("R2 stall hold", fetch_addr, 16'h1234);

        man_word(16'h1111);
        chk("R2 step", fetch_addr, 16'h1235);
        chk("R4 first word", next_instr, 16'h1111);
        chk("R4 cur untouched", cur_instr, 16'h0000);
        chk("R4 not valid", cur_valid, 0);

        man_word(16'h2222);
        chk("R5 shift cur", cur_instr, 16'h1111);
        chk("R5 shift next", next_instr, 16'h2222);
        chk("R5 shift imm", imm_data, 16'h2222);
        chk("R6 valid", cur_valid, 1);
        chk("R6 no req", fetch_req, 0);

        man_word(16'h9999); // acknowledge without a request
        chk("R2 idle ack addr", fetch_addr, 16'h1236);
        chk("R2 idle ack next", next_instr, 16'h2222);
        @(negedge clk);
        chk("R6 still valid", cur_valid, 1);

        consume = 1'b1;
        @(negedge clk);
        consume = 1'b0;
        chk("R8 drop", cur_valid, 0);
        man_word(16'h0004);
        chk("R5 cur after consume", cur_instr, 16'h2222);
        consume = 1'b1;
        @(negedge clk);
        consume = 1'b0;
        man_word(16'h5555);
        chk("R7 cur imm instr", cur_instr, 16'h0004);
        chk("R7 waiting", cur_valid, 0);
        consume = 1'b1; // ignored: nothing valid to retire
        @(negedge clk);
        consume = 1'b0;
        chk("R7 extra req", fetch_req, 1);
        chk("R8 ignored consume", cur_instr, 16'h0004);
        man_word(16'h6666);
        chk("R7 next only", next_instr, 16'h6666);
        chk("R7 imm kept", imm_data, 16'h5555);
        chk("R7 cur kept", cur_instr, 16'h0004);
        chk("R7 valid", cur_valid, 1);
        chk("R2 addr", fetch_addr, 16'h1239);

        consume = 1'b1;
        @(negedge clk);
        consume = 1'b0;
        man_ack = 1'b1; man_data = 16'hABCD;
        redirect = 1'b1; redirect_addr = 16'hFFFF;
        @(negedge clk);
        man_ack = 1'b0; redirect = 1'b0;
        chk("R3 mid-fill addr", fetch_addr, 16'hFFFF);
        chk("R3 mid-fill discard", next_instr, 16'h6666);
        chk("R3 mid-fill valid", cur_valid, 0);
        man_word(16'h0010);
        chk("R2 wrap", fetch_addr, 16'h0000);
        chk("R4 after flush", next_instr, 16'h0010);

        for (int l = 0; l < 3; l++) begin
            for (int c = 0; c < 3; c++) begin
                lat = l;
                run_stream(16'h0000, c, 20);
                run_stream(16'h7FFE, c, 20);
                run_stream(16'hFFFD, c, 20);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule